// File: doc/BRIEF.md
# Interrupt Pending and Mask Controller

This block holds the interrupt state for a bank of peripheral lines (64 by default). Each line can be raised in two ways: as a pulse, by a one-cycle strobe carrying a line index, or as a level, through a dedicated input bit per line. Every line has a raw pending bit, a masked status bit and an enable bit. The raw pending bit records every raise. The status bit records only the raises that land while the line is enabled. A global lock lets software hold off the CPU while raises keep being recorded. A CPU wake pulse tells a sleeping core that something was raised. An immediate-dispatch pulse asks the core to take an interrupt that has just become deliverable. Choosing between pending lines by priority is done outside this block.

All command inputs are plain strobes, and every strobe is taken in the cycle it is high. There is no valid/ready handshake and no back-pressure: the block never stalls a command. Both vectors are outputs that are valid every cycle. The wake and dispatch outputs are single-cycle pulses.

When several commands meet in the same cycle, they are applied in a fixed order:
1. Enable and disable update the mask. Enable wins if both name the same line.
2. Clear-all, or else clear-all-enabled, is applied. Clear-all-enabled uses the mask as it stood before that cycle.
3. A single-line clear is applied.
4. New raises set their bits. A raise therefore wins over a clear of the same line.

Top module: `irqc_top`

## Requirements
- R1: A pulse raise on line i sets bit i of `pend_raw` after the next clock edge. It sets bit i of `pend_stat` only if line i is enabled.
- R2: An enable of line i whose raw bit is 1 sets its status bit. It pulses `dispatch` for one cycle unless the lock is held, in which case no dispatch is issued.
- R3: A disable of line i clears only its enable bit. Both vectors keep their values, and a later raise of line i sets only the raw bit.
- R4: A single-line clear of line i zeroes bit i in both `pend_raw` and `pend_stat`.
- R5: Clear-all-enabled zeroes `pend_stat` and zeroes only the enabled bits of `pend_raw`. Clear-all zeroes both vectors.
- R6: A level input raises its line only on a 0-to-1 change. A line that stays high does not pend again after it is cleared.
- R7: A handler-exit re-evaluation of line i whose level input is still 1 sets raw bit i again, and sets status bit i too if the line is enabled. With the level at 0 it changes nothing.
- R8: While the lock is held, raises still update both vectors but `wake` stays low. Releasing a held lock while `pend_stat` is non-zero pulses `dispatch` once. Releasing it with `pend_stat` at zero does not.
- R9: A raise (pulse or level edge) while unlocked pulses `wake` for exactly one cycle, after the next clock edge, even if the line is masked.
- R10: The hard-fault strobe pulses `wake` for exactly one cycle even while the lock is held.
- R11: An index of `NLINES` or more on any indexed command is ignored and sets the sticky output `idx_err`, which stays 1 until reset.
- R12: Reset clears the mask, both vectors, the lock, `wake`, `dispatch` and `idx_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_vld | input | 1 | Pulse-raise strobe |
| raise_idx | input | IW | Line index for pulse raise |
| lvl_in | input | NLINES | Level interrupt inputs, one per line |
| en_vld | input | 1 | Enable strobe |
| en_idx | input | IW | Line index to enable |
| dis_vld | input | 1 | Disable strobe |
| dis_idx | input | IW | Line index to disable |
| clr_vld | input | 1 | Single-line clear strobe |
| clr_idx | input | IW | Line index to clear |
| reeval_vld | input | 1 | Handler-exit re-evaluation strobe |
| reeval_idx | input | IW | Line index to re-evaluate |
| clr_all | input | 1 | Clear both vectors |
| clr_all_en | input | 1 | Clear status and the enabled raw bits |
| lock_set | input | 1 | Take the global lock (wins over release) |
| lock_rel | input | 1 | Release the global lock |
| hard_wake | input | 1 | Hard-fault strobe that wakes through the lock |
| pend_raw | output | NLINES | Pending vector before masking |
| pend_stat | output | NLINES | Pending vector after masking |
| wake | output | 1 | One-cycle CPU wake pulse |
| dispatch | output | 1 | One-cycle immediate-dispatch request |
| idx_err | output | 1 | Sticky out-of-range index flag |

## Verification
Every result is registered exactly once. A strobe driven in cycle k shows its effect on `pend_raw`, `pend_stat`, `idx_err`, `wake` and `dispatch` in cycle k+1, and the two pulses return low in cycle k+2. The driver stamps each expected item with the cycle in which it falls due. The monitor samples on the falling edge and compares an item only when its due cycle arrives. Each stimulus is followed by a check of the very next cycle, so a pulse that lasts too long, or arrives a cycle late, shows up as a mismatch.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // command ports that carry a line index
  typedef enum int {
    P_RAISE  = 0,
    P_EN     = 1,
    P_DIS    = 2,
    P_CLR    = 3,
    P_REEVAL = 4
  } port_e;
  localparam int NPORT = 5;
endpackage

// File: rtl/irqc_sel.sv
module irqc_sel #(
  parameter int NLINES = 64,
  parameter int IW     = 7
) (
  input  logic              vld,
  input  logic [IW-1:0]     idx,
  output logic [NLINES-1:0] hot,
  output logic              bad
);
  always_comb begin
    hot = '0;
    bad = 1'b0;
    if (vld) begin
      if (int'(idx) < NLINES) hot[int'(idx)] = 1'b1;
      else                    bad = 1'b1;
    end
  end
endmodule

// File: rtl/irqc_lvl.sv
module irqc_lvl #(
  parameter int NLINES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lvl_in,
  output logic [NLINES-1:0] rise
);
  logic [NLINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_in;
  end

  assign rise = lvl_in & ~prev_q;

  // R6
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/irqc_state.sv
module irqc_state #(
  parameter int NLINES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] raise_hot,
  input  logic [NLINES-1:0] en_hot,
  input  logic [NLINES-1:0] dis_hot,
  input  logic [NLINES-1:0] clr_hot,
  input  logic [NLINES-1:0] reeval_hot,
  input  logic [NLINES-1:0] lvl_in,
  input  logic [NLINES-1:0] lvl_rise,
  input  logic              bad_any,
  input  logic              clr_all,
  input  logic              clr_all_en,
  input  logic              lock_set,
  input  logic              lock_rel,
  input  logic              hard_wake,
  output logic [NLINES-1:0] pend_raw,
  output logic [NLINES-1:0] pend_stat,
  output logic              wake,
  output logic              dispatch,
  output logic              idx_err
);
  logic [NLINES-1:0] mask_q, raw_q, stat_q;
  logic [NLINES-1:0] mask_n, raw_n, stat_n, set_v, en_hit;
  logic              lock_q, lock_n, wake_q, disp_q, err_q;
  logic              wake_n, disp_n;

  always_comb begin
    mask_n = (mask_q & ~dis_hot) | en_hot;
    raw_n  = raw_q;
    stat_n = stat_q;
    if (clr_all) begin
      raw_n  = '0;
      stat_n = '0;
    end else if (clr_all_en) begin
      raw_n  = raw_q & ~mask_q;
      stat_n = '0;
    end
    raw_n  = raw_n & ~clr_hot;
    stat_n = stat_n & ~clr_hot;
    set_v  = raise_hot | lvl_rise | (reeval_hot & lvl_in);
    raw_n  = raw_n | set_v;
    stat_n = stat_n | (set_v & mask_n);
    en_hit = en_hot & raw_n;
    stat_n = stat_n | en_hit;
    lock_n = lock_set ? 1'b1 : (lock_rel ? 1'b0 : lock_q);
    wake_n = (((raise_hot | lvl_rise) != '0) && !lock_q) || hard_wake;
    disp_n = ((en_hit != '0) && !lock_q) ||
             (lock_q && !lock_n && (stat_n != '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
      stat_q <= '0;
      lock_q <= 1'b0;
      wake_q <= 1'b0;
      disp_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mask_q <= mask_n;
      raw_q  <= raw_n;
      stat_q <= stat_n;
      lock_q <= lock_n;
      wake_q <= wake_n;
      disp_q <= disp_n;
      err_q  <= err_q | bad_any;
    end
  end

  assign pend_raw  = raw_q;
  assign pend_stat = stat_q;
  assign wake      = wake_q;
  assign dispatch  = disp_q;
  assign idx_err   = err_q;

  // R1
  raise_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_hot != '0) |=> ((raw_q & $past(raise_hot)) == $past(raise_hot)));

  // R5
  stat_within_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~raw_q) == '0);

  // R3
  disable_keeps_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dis_hot != '0) && !clr_all && !clr_all_en && (clr_hot == '0) &&
     (set_v == '0) && (en_hot == '0))
    |=> (raw_q == $past(raw_q)) && (stat_q == $past(stat_q)));

  // R8
  lock_blocks_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !hard_wake) |=> !wake_q);

  // R10
  hard_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_wake |=> wake_q);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NLINES = 64,
  localparam int IW = $clog2(NLINES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_vld,
  input  logic [IW-1:0]     raise_idx,
  input  logic [NLINES-1:0] lvl_in,
  input  logic              en_vld,
  input  logic [IW-1:0]     en_idx,
  input  logic              dis_vld,
  input  logic [IW-1:0]     dis_idx,
  input  logic              clr_vld,
  input  logic [IW-1:0]     clr_idx,
  input  logic              reeval_vld,
  input  logic [IW-1:0]     reeval_idx,
  input  logic              clr_all,
  input  logic              clr_all_en,
  input  logic              lock_set,
  input  logic              lock_rel,
  input  logic              hard_wake,
  output logic [NLINES-1:0] pend_raw,
  output logic [NLINES-1:0] pend_stat,
  output logic              wake,
  output logic              dispatch,
  output logic              idx_err
);
  logic              vld_a [NPORT];
  logic [IW-1:0]     idx_a [NPORT];
  logic [NLINES-1:0] hot_a [NPORT];
  logic [NPORT-1:0]  bad_a;
  logic [NLINES-1:0] lvl_rise;

  always_comb begin
    vld_a[P_RAISE]  = raise_vld;  idx_a[P_RAISE]  = raise_idx;
    vld_a[P_EN]     = en_vld;     idx_a[P_EN]     = en_idx;
    vld_a[P_DIS]    = dis_vld;    idx_a[P_DIS]    = dis_idx;
    vld_a[P_CLR]    = clr_vld;    idx_a[P_CLR]    = clr_idx;
    vld_a[P_REEVAL] = reeval_vld; idx_a[P_REEVAL] = reeval_idx;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_sel
    irqc_sel #(.NLINES(NLINES), .IW(IW)) u_sel (
      .vld (vld_a[p]),
      .idx (idx_a[p]),
      .hot (hot_a[p]),
      .bad (bad_a[p])
    );
  end

  irqc_lvl #(.NLINES(NLINES)) u_lvl (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in (lvl_in),
    .rise   (lvl_rise)
  );

  irqc_state #(.NLINES(NLINES)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .raise_hot  (hot_a[P_RAISE]),
    .en_hot     (hot_a[P_EN]),
    .dis_hot    (hot_a[P_DIS]),
    .clr_hot    (hot_a[P_CLR]),
    .reeval_hot (hot_a[P_REEVAL]),
    .lvl_in     (lvl_in),
    .lvl_rise   (lvl_rise),
    .bad_any    (|bad_a),
    .clr_all    (clr_all),
    .clr_all_en (clr_all_en),
    .lock_set   (lock_set),
    .lock_rel   (lock_rel),
    .hard_wake  (hard_wake),
    .pend_raw   (pend_raw),
    .pend_stat  (pend_stat),
    .wake       (wake),
    .dispatch   (dispatch),
    .idx_err    (idx_err)
  );

  // R9
  wake_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(raise_vld || hard_wake || (lvl_rise != '0)));
endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;
  localparam int N  = 64;
  localparam int IW = $clog2(N) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic raise_vld = 0, en_vld = 0, dis_vld = 0, clr_vld = 0, reeval_vld = 0;
  logic [IW-1:0] raise_idx = '0, en_idx = '0, dis_idx = '0, clr_idx = '0, reeval_idx = '0;
  logic [N-1:0] lvl_in = '0;
  logic clr_all = 0, clr_all_en = 0, lock_set = 0, lock_rel = 0, hard_wake = 0;
  logic [N-1:0] pend_raw, pend_stat;
  logic wake, dispatch, idx_err;

  irqc_top uut (
    .clk(clk), .rst_n(rst_n),
    .raise_vld(raise_vld), .raise_idx(raise_idx), .lvl_in(lvl_in),
    .en_vld(en_vld), .en_idx(en_idx), .dis_vld(dis_vld), .dis_idx(dis_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx),
    .reeval_vld(reeval_vld), .reeval_idx(reeval_idx),
    .clr_all(clr_all), .clr_all_en(clr_all_en),
    .lock_set(lock_set), .lock_rel(lock_rel), .hard_wake(hard_wake),
    .pend_raw(pend_raw), .pend_stat(pend_stat),
    .wake(wake), .dispatch(dispatch), .idx_err(idx_err)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [N-1:0] raw;
    logic [N-1:0] stat;
    logic wake;
    logic disp;
    logic err;
    int due;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  logic [N-1:0] m_raw = '0, m_stat = '0, m_mask = '0;
  logic m_lock = 0, m_err = 0, e_wake = 0, e_disp = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare each item in the cycle it falls due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pend_raw !== e.raw || pend_stat !== e.stat || wake !== e.wake ||
          dispatch !== e.disp || idx_err !== e.err) begin
        errors++;
        $display("FAIL %s: raw=%h stat=%h wake=%b disp=%b err=%b exp raw=%h stat=%h wake=%b disp=%b err=%b",
                 e.tag, pend_raw, pend_stat, wake, dispatch, idx_err,
                 e.raw, e.stat, e.wake, e.disp, e.err);
      end
    end
  end

  task automatic tick(string tag);
    exp_t e;
    e.raw = m_raw; e.stat = m_stat; e.wake = e_wake; e.disp = e_disp;
    e.err = m_err; e.due = cyc + 1; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    raise_vld = 0; en_vld = 0; dis_vld = 0; clr_vld = 0; reeval_vld = 0;
    clr_all = 0; clr_all_en = 0; lock_set = 0; lock_rel = 0; hard_wake = 0;
    e_wake = 0; e_disp = 0;
  endtask

  function automatic logic [N-1:0] bit_of(int i);
    return (i < N) ? (N'(1) << i) : '0;
  endfunction

  task automatic pulse(int i, string tag);
    raise_vld = 1; raise_idx = IW'(i);
    if (i >= N) m_err = 1;
    else begin
      m_raw |= bit_of(i); m_stat |= bit_of(i) & m_mask; e_wake = !m_lock;
    end
    tick(tag);
  endtask

  task automatic enable(int i, string tag);
    en_vld = 1; en_idx = IW'(i);
    m_mask |= bit_of(i);
    if ((m_raw & bit_of(i)) != '0) begin
      m_stat |= bit_of(i); e_disp = !m_lock;
    end
    tick(tag);
  endtask

  task automatic disable_ln(int i, string tag);
    dis_vld = 1; dis_idx = IW'(i); m_mask &= ~bit_of(i); tick(tag);
  endtask

  task automatic clear(int i, string tag);
    clr_vld = 1; clr_idx = IW'(i);
    m_raw &= ~bit_of(i); m_stat &= ~bit_of(i); tick(tag);
  endtask

  task automatic reeval(int i, string tag);
    reeval_vld = 1; reeval_idx = IW'(i);
    if (lvl_in[i]) begin m_raw |= bit_of(i); m_stat |= bit_of(i) & m_mask; end
    tick(tag);
  endtask

  task automatic level(int i, logic v, string tag);
    if (v && !lvl_in[i]) begin
      m_raw |= bit_of(i); m_stat |= bit_of(i) & m_mask; e_wake = !m_lock;
    end
    lvl_in[i] = v;
    tick(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    checks++;
    if (pend_raw !== '0 || pend_stat !== '0 || wake !== 0 || dispatch !== 0 || idx_err !== 0) begin
      errors++;
      $display("FAIL R12: raw=%h stat=%h wake=%b disp=%b err=%b expected all zero",
               pend_raw, pend_stat, wake, dispatch, idx_err);
    end
    pulse(3, "R1 R9 masked raise");
    tick("R9 wake single cycle");
    enable(3, "R2 enable pending line");
    tick("R2 dispatch single cycle");
    enable(5, "R2 enable idle line");
    pulse(5, "R1 enabled raise");
    disable_ln(5, "R3 disable keeps vectors");
    clear(5, "R4 single clear");
    pulse(5, "R3 raise after disable");
    clr_all_en = 1; m_raw &= ~m_mask; m_stat = '0; tick("R5 clear all enabled");
    clr_all = 1; m_raw = '0; m_stat = '0; tick("R5 clear all");
    level(10, 1, "R6 level rise");
    tick("R6 level held");
    clear(10, "R4 clear level line");
    tick("R6 no re-pend while high");
    enable(10, "R7 enable level line");
    reeval(10, "R7 reeval high");
    level(10, 0, "R7 lower level");
    clear(10, "R7 clear");
    reeval(10, "R7 reeval low");
    enable(63, "R2 enable top line");
    lock_set = 1; m_lock = 1; tick("R8 take lock");
    pulse(63, "R8 raise while locked");
    hard_wake = 1; e_wake = 1; tick("R10 hard wake");
    tick("R10 single wake");
    pulse(2, "R8 masked raise locked");
    enable(2, "R2 enable while locked");
    lock_rel = 1; m_lock = 0; e_disp = 1; tick("R8 release dispatch");
    tick("R8 dispatch single");
    clr_all = 1; m_raw = '0; m_stat = '0; tick("R5 clear all again");
    lock_set = 1; m_lock = 1; tick("R8 lock again");
    lock_rel = 1; m_lock = 0; tick("R8 release empty");
    pulse(64, "R11 bad index");
    en_vld = 1; en_idx = IW'(100); m_err = 1; tick("R11 bad enable");
    pulse(0, "R11 sticky err");
    tick("final idle");
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule